// File: doc/BRIEF.md
# Tournament Parent Selection Unit

This unit picks two parents for a hardware genetic-algorithm engine. A start pulse begins one selection. The unit then draws four pseudo-random population indices from a free-running LFSR and reads the four matching fitness values through one read port. It settles two independent two-way tournaments and reports the chromosome addresses of both winners. A single-cycle done pulse marks that both addresses are valid.

The fitness memory is split into two banks, one for parents and one for children. The top address bit selects the bank. The bank-select input, sampled at start, chooses which half is read. Each raw random index is folded into the range 0 to `pop_size`-1 before the bank bit is placed on top of it.

The read port is a fixed-latency memory port rather than a stream. Data returns exactly one cycle after `fit_rd_en`, and no back-pressure is possible on it. The `sel_start`/`sel_done` pair is a plain control handshake: a start pulse that arrives while a selection is in progress is dropped.

Top module: `tourney_select`

## Requirements
- R1: A `sel_start` high sampled while idle begins one selection. `sel_done` is high for exactly one cycle, the 7th cycle after the sampling edge. Cycle 1 is the one right after that edge.
- R2: Each selection issues exactly four reads, one per cycle, in cycles 1 to 4. `fit_rd_en` is low in every other cycle.
- R3: Bit 8 (the MSB) of every `fit_rd_addr` in a selection equals `bank_hi` as sampled at start.
- R4: Bits 7:0 of every read address form an index below `pop_size` as sampled at start. `pop_size` must lie in 1..256. With `pop_size`=1, every index is 0.
- R5: Reads 1 and 2 form tournament A and reads 3 and 4 form tournament B. Each tournament is won by the larger fitness, compared as an unsigned number. `parent_a` and `parent_b` carry the full 9-bit address of the winner of A and B respectively.
- R6: When the two fitness values in a tournament are equal, the earlier read of that pair wins.
- R7: `parent_a` and `parent_b` change only in the cycle where `sel_done` is high, and hold their values until the next done.
- R8: `sel_start` is ignored while a selection is in progress. A start held high through a selection begins the next one on the edge that ends the done cycle.
- R9: After reset, `sel_done` and `fit_rd_en` are low and both parent outputs are 0.
- R10: The random source advances on every clock cycle, so successive selections read different address sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_start | input | 1 | Begin one selection (sampled while idle) |
| bank_hi | input | 1 | Fitness bank to read: 0 lower half, 1 upper half |
| pop_size | input | 9 | Number of individuals per bank, 1..256 |
| fit_rd_en | output | 1 | Fitness memory read strobe |
| fit_rd_addr | output | 9 | Fitness memory read address {bank, index} |
| fit_rd_data | input | 8 | Fitness value, valid one cycle after the strobe |
| parent_a | output | 9 | Address of the winner of tournament A |
| parent_b | output | 9 | Address of the winner of tournament B |
| sel_done | output | 1 | One-cycle pulse: both parent addresses valid |

## Verification
The bound checker watches several properties on every cycle. It confirms that reads occur only during a selection and that each address carries the latched bank bit and an in-range index. It also confirms that exactly four reads precede each done pulse, that done lasts one cycle, and that each winner is one of the two addresses of its own pair. Only the bench scenarios can show the rest: that the larger fitness really wins, that ties go to the first read, and that the done cycle is exact. Those scenarios also cover dropped restarts, back-to-back selections with start held high, the single-individual population and the variation between successive selections.

// File: rtl/tsel_pkg.sv
package tsel_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_READ  = 2'd1,
    S_DRAIN = 2'd2,
    S_PICK  = 2'd3
  } tsel_state_e;
endpackage

// File: rtl/tsel_lfsr.sv
module tsel_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] q
);
  // Galois form, right shift; steps on every clock
  always_ff @(posedge clk) begin
    if (!rst_n) q <= SEED;
    else if (q[0]) q <= (q >> 1) ^ TAPS;
    else q <= q >> 1;
  end
endmodule

// File: rtl/tsel_fold.sv
module tsel_fold #(
  parameter int IDX_W = 8
) (
  input  logic [IDX_W-1:0] raw,
  input  logic [IDX_W:0]   modulus,
  output logic [IDX_W-1:0] idx
);
  localparam int RW = 2 * IDX_W + 1;

  logic [RW-1:0] rem [IDX_W+1];

  assign rem[IDX_W] = RW'(raw);

  // restoring remainder: one conditional subtraction per shifted modulus
  for (genvar k = 0; k < IDX_W; k++) begin : g_step
    logic [RW-1:0] shifted;
    assign shifted = RW'(modulus) << k;
    assign rem[k] = (modulus != '0 && rem[k+1] >= shifted) ?
                    rem[k+1] - shifted : rem[k+1];
  end

  assign idx = rem[0][IDX_W-1:0];
endmodule

// File: rtl/tsel_pick.sv
module tsel_pick #(
  parameter int FIT_W  = 8,
  parameter int ADDR_W = 9
) (
  input  logic [FIT_W-1:0]  fit_first,
  input  logic [FIT_W-1:0]  fit_second,
  input  logic [ADDR_W-1:0] addr_first,
  input  logic [ADDR_W-1:0] addr_second,
  output logic [ADDR_W-1:0] winner
);
  // second wins only when strictly larger, so ties keep the first
  assign winner = (fit_second > fit_first) ? addr_second : addr_first;
endmodule

// File: rtl/tourney_select.sv
module tourney_select
  import tsel_pkg::*;
#(
  parameter int              FIT_W     = 8,
  parameter int              ADDR_W    = 9,
  parameter int              LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_start,
  input  logic              bank_hi,
  input  logic [ADDR_W-1:0] pop_size,
  output logic              fit_rd_en,
  output logic [ADDR_W-1:0] fit_rd_addr,
  input  logic [FIT_W-1:0]  fit_rd_data,
  output logic [ADDR_W-1:0] parent_a,
  output logic [ADDR_W-1:0] parent_b,
  output logic              sel_done
);
  localparam int IDX_W  = ADDR_W - 1;
  localparam int NCAND  = 4;
  localparam int NPAIR  = NCAND / 2;
  localparam int CW     = $clog2(NCAND);

  tsel_state_e       state;
  logic [CW-1:0]     rd_cnt;
  logic [CW-1:0]     cap_cnt;
  logic              rd_vld;
  logic              bank_q;
  logic [IDX_W:0]    pop_q;
  logic [ADDR_W-1:0] cand_addr [NCAND];
  logic [FIT_W-1:0]  cand_fit  [NCAND];
  logic [ADDR_W-1:0] win       [NPAIR];
  logic [LFSR_W-1:0] rnd;
  logic [IDX_W-1:0]  idx;

  tsel_lfsr #(
    .W    (LFSR_W),
    .TAPS (LFSR_W'(16'hB400)),
    .SEED (LFSR_SEED)
  ) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .q     (rnd)
  );

  tsel_fold #(.IDX_W(IDX_W)) u_fold (
    .raw     (rnd[IDX_W-1:0]),
    .modulus (pop_q),
    .idx     (idx)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    tsel_pick #(.FIT_W(FIT_W), .ADDR_W(ADDR_W)) u_pick (
      .fit_first   (cand_fit[2*p]),
      .fit_second  (cand_fit[2*p+1]),
      .addr_first  (cand_addr[2*p]),
      .addr_second (cand_addr[2*p+1]),
      .winner      (win[p])
    );
  end

  assign fit_rd_en   = (state == S_READ);
  assign fit_rd_addr = {bank_q, idx};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      rd_cnt   <= '0;
      cap_cnt  <= '0;
      rd_vld   <= 1'b0;
      bank_q   <= 1'b0;
      pop_q    <= '0;
      parent_a <= '0;
      parent_b <= '0;
      sel_done <= 1'b0;
      for (int i = 0; i < NCAND; i++) begin
        cand_addr[i] <= '0;
        cand_fit[i]  <= '0;
      end
    end else begin
      sel_done <= 1'b0;
      rd_vld   <= fit_rd_en;
      if (rd_vld) begin
        cand_fit[cap_cnt] <= fit_rd_data;
        cap_cnt           <= cap_cnt + 1'b1;
      end
      unique case (state)
        S_IDLE: begin
          if (sel_start) begin
            bank_q  <= bank_hi;
            pop_q   <= pop_size;
            rd_cnt  <= '0;
            cap_cnt <= '0;
            state   <= S_READ;
          end
        end
        S_READ: begin
          cand_addr[rd_cnt] <= fit_rd_addr;
          rd_cnt            <= rd_cnt + 1'b1;
          if (rd_cnt == CW'(NCAND - 1)) state <= S_DRAIN;
        end
        S_DRAIN: state <= S_PICK;
        S_PICK: begin
          parent_a <= win[0];
          parent_b <= win[1];
          sel_done <= 1'b1;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tsel_chk.sv
module tsel_chk #(
  parameter int FIT_W  = 8,
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_start,
  input logic              bank_hi,
  input logic [ADDR_W-1:0] pop_size,
  input logic              fit_rd_en,
  input logic [ADDR_W-1:0] fit_rd_addr,
  input logic [FIT_W-1:0]  fit_rd_data,
  input logic [ADDR_W-1:0] parent_a,
  input logic [ADDR_W-1:0] parent_b,
  input logic              sel_done
);
  logic              busy;
  logic              bank_c;
  logic [ADDR_W-1:0] pop_c;
  logic [2:0]        nreads;
  logic [ADDR_W-1:0] rec [4];
  logic              accept;

  assign accept = sel_start && (!busy || sel_done);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      bank_c <= 1'b0;
      pop_c  <= '0;
      nreads <= '0;
      for (int i = 0; i < 4; i++) rec[i] <= '0;
    end else begin
      if (sel_done) busy <= 1'b0;
      if (accept) begin
        busy   <= 1'b1;
        bank_c <= bank_hi;
        pop_c  <= pop_size;
        nreads <= '0;
      end else if (fit_rd_en) begin
        rec[nreads[1:0]] <= fit_rd_addr;
        nreads           <= nreads + 3'd1;
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sel_done |=> !sel_done); // R1
  AST_FOUR_READS: assert property (@(posedge clk) disable iff (!rst_n)
    sel_done |-> nreads == 3'd4); // R2
  AST_READ_IN_SELECTION: assert property (@(posedge clk) disable iff (!rst_n)
    fit_rd_en |-> busy); // R8
  AST_BANK_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    fit_rd_en |-> fit_rd_addr[ADDR_W-1] == bank_c); // R3
  AST_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    fit_rd_en |-> {1'b0, fit_rd_addr[ADDR_W-2:0]} < pop_c); // R4
  AST_PARENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_done |-> ($stable(parent_a) && $stable(parent_b))); // R7
  AST_WINNER_A_FROM_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    sel_done |-> (parent_a == rec[0] || parent_a == rec[1])); // R5
  AST_WINNER_B_FROM_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    sel_done |-> (parent_b == rec[2] || parent_b == rec[3])); // R5
endmodule

bind tourney_select tsel_chk #(.FIT_W(FIT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sel_start   (sel_start),
  .bank_hi     (bank_hi),
  .pop_size    (pop_size),
  .fit_rd_en   (fit_rd_en),
  .fit_rd_addr (fit_rd_addr),
  .fit_rd_data (fit_rd_data),
  .parent_a    (parent_a),
  .parent_b    (parent_b),
  .sel_done    (sel_done)
);

// File: tb/tourney_select_bench.sv
`timescale 1ns/1ps
module tourney_select_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_start = 1'b0;
  logic       bank_hi = 1'b0;
  logic [8:0] pop_size = 9'd8;
  logic       fit_rd_en;
  logic [8:0] fit_rd_addr;
  logic [7:0] fit_rd_data = 8'd0;
  logic [8:0] parent_a, parent_b;
  logic       sel_done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [7:0] mem [512];
  logic [8:0] rq [$];
  int         phase = -1;
  logic       exp_bank;
  int         exp_pop;
  logic [8:0] last_a = '0, last_b = '0;
  logic [35:0] prev_set = '0;
  int         nsel = 0, ndiff = 0, nties = 0;

  always #5 clk = ~clk;

  tourney_select u_tourney_select (
    .clk(clk), .rst_n(rst_n), .sel_start(sel_start), .bank_hi(bank_hi),
    .pop_size(pop_size), .fit_rd_en(fit_rd_en), .fit_rd_addr(fit_rd_addr),
    .fit_rd_data(fit_rd_data), .parent_a(parent_a), .parent_b(parent_b),
    .sel_done(sel_done)
  );

  // memory model: one-cycle read latency
  always @(posedge clk) if (fit_rd_en) fit_rd_data <= mem[fit_rd_addr];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model: phase 1..7 counts cycles of an accepted selection
  always @(posedge clk) begin
    if (!rst_n) phase = -1;
    else if (phase >= 1 && phase < 7) phase = phase + 1;
    else begin
      phase = -1;
      if (sel_start) begin
        phase = 1;
        exp_bank = bank_hi;
        exp_pop = int'(pop_size);
        rq.delete();
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(fit_rd_en == (phase >= 1 && phase <= 4), "R2 read strobe", fit_rd_en, phase >= 1 && phase <= 4);
      if (fit_rd_en) begin
        rq.push_back(fit_rd_addr);
        chk(fit_rd_addr[8] == exp_bank, "R3 bank bit", fit_rd_addr[8], exp_bank);
        chk(int'(fit_rd_addr[7:0]) < exp_pop, "R4 index range", fit_rd_addr[7:0], exp_pop - 1);
      end
      chk(sel_done == (phase == 7), "R1 done timing", sel_done, phase == 7);
      if (phase == 7) begin
        logic [8:0] ea, eb;
        chk(rq.size() == 4, "R2 read count", rq.size(), 4);
        if (rq.size() == 4) begin
          ea = (mem[rq[1]] > mem[rq[0]]) ? rq[1] : rq[0];
          eb = (mem[rq[3]] > mem[rq[2]]) ? rq[3] : rq[2];
          chk(parent_a == ea, "R5 winner A", parent_a, ea);
          chk(parent_b == eb, "R5 winner B", parent_b, eb);
          if (mem[rq[0]] == mem[rq[1]]) begin
            nties++;
            chk(parent_a == rq[0], "R6 tie A keeps first", parent_a, rq[0]);
          end
          if (mem[rq[2]] == mem[rq[3]])
            chk(parent_b == rq[2], "R6 tie B keeps first", parent_b, rq[2]);
          if (nsel > 0 && {rq[0], rq[1], rq[2], rq[3]} != prev_set) ndiff++;
          prev_set = {rq[0], rq[1], rq[2], rq[3]};
          nsel++;
        end
      end else begin
        chk(parent_a == last_a && parent_b == last_b, "R7 parents hold",
            int'({parent_a, parent_b}), int'({last_a, last_b}));
      end
      last_a = parent_a;
      last_b = parent_b;
    end
  end

  task automatic run_sel(input int pop, input bit bank);
    @(negedge clk);
    pop_size = 9'(pop);
    bank_hi = bank;
    sel_start = 1'b1;
    @(negedge clk);
    sel_start = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (512) begin end
    for (int i = 0; i < 512; i++) mem[i] = 8'((i * 37 + 11) & 255);
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(sel_done == 1'b0, "R9 done after reset", sel_done, 0);
    chk(fit_rd_en == 1'b0, "R9 strobe after reset", fit_rd_en, 0);
    chk(parent_a == 9'd0 && parent_b == 9'd0, "R9 parents after reset",
        int'({parent_a, parent_b}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_sel(200, 1'b0);
    run_sel(256, 1'b1);
    run_sel(5, 1'b0);
    run_sel(3, 1'b1);
    // R4 corner: single individual, all four reads hit index 0 (ties)
    run_sel(1, 1'b1);
    run_sel(1, 1'b0);

    // R6: all fitness values equal
    for (int i = 0; i < 512; i++) mem[i] = 8'd42;
    run_sel(16, 1'b0);
    run_sel(100, 1'b1);

    // unsigned extremes: alternate 0xFF and 0x00
    for (int i = 0; i < 512; i++) mem[i] = (i % 2 == 1) ? 8'hFF : 8'h00;
    run_sel(64, 1'b0);
    run_sel(64, 1'b1);

    // R8: extra start pulses in the middle of a selection are dropped
    for (int i = 0; i < 512; i++) mem[i] = 8'((i * 73 + 5) & 255);
    @(negedge clk);
    pop_size = 9'd50; bank_hi = 1'b0; sel_start = 1'b1;
    @(negedge clk);
    sel_start = 1'b0;
    repeat (2) @(negedge clk);
    sel_start = 1'b1; bank_hi = 1'b1; pop_size = 9'd2;
    @(negedge clk);
    sel_start = 1'b0;
    repeat (8) @(negedge clk);

    // R8: start held high -> back-to-back selections
    @(negedge clk);
    pop_size = 9'd30; bank_hi = 1'b1; sel_start = 1'b1;
    repeat (20) @(negedge clk);
    sel_start = 1'b0;
    repeat (10) @(negedge clk);

    // R10: selections must not all read the same addresses
    chk(ndiff > 0, "R10 selections vary", ndiff, 1);
    chk(nties > 0, "R6 ties exercised", nties, 1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule